// File: doc/BRIEF.md
# Multi-device SAR ADC readout controller

This controller sits on the host side of a group of 16-bit successive-approximation converters. The converters share a conversion line, a serial clock and a serial data line. Each converter has its own active-low select line. On a start request the controller raises the conversion line while every select is high, so every converter begins converting in chip-select mode at the same moment. It then keeps all selects high for a fixed worst-case conversion wait, so no converter ever produces a busy indication.

After the wait, the controller reads the devices one at a time in index order. It lowers one select and waits an enable delay, during which the device places its most significant bit on the data line. It then generates 16 serial clock pulses and samples the data line on each falling edge that it drives. After the 16th falling edge it raises the select again, leaving the line free for the next device. When the last word has been captured, the conversion line drops. All words are then presented together on a result port with a valid/ready handshake. The controller then enforces an acquisition time before it starts another conversion.

The result port holds its value under back-pressure: `res_valid` stays high and `res_data` stays frozen until `res_ready` is seen high. No new conversion is started while a result is still waiting, so no sample is overwritten. The data move into the host only when valid and ready are both high at a clock edge. With `res_ready` held high, `res_valid` is a one-cycle pulse. All timing values are counts of system-clock cycles, set by parameters (`CONV_CYC`, `EN_CYC`, `SCKH_CYC`, `SCKL_CYC`, `ACQ_CYC`), and each must be at least 1.

Top module: `adc_multi_reader`

## Requirements
- R1: While reset is asserted and right after it is released, `cnv` is 0, `sck` is 0, every bit of `sel_n` is 1 and `res_valid` is 0.
- R2: When the controller is idle, no result is pending and `start` is sampled high, `cnv` rises at the next edge with every `sel_n` bit high. All selects then stay high for exactly `CONV_CYC` cycles before the first select drops.
- R3: Devices are read in index order 0 to NDEV-1, once each per conversion. At most one `sel_n` bit is low at any time, and all selects are high for at least one cycle between two devices.
- R4: From the cycle a select goes low until the first `sck` rise there are exactly `EN_CYC` cycles with `sck` low.
- R5: Each select window holds exactly 16 `sck` pulses. Each pulse is high for `SCKH_CYC` cycles, the gap between pulses is low for `SCKL_CYC` cycles, and the select rises on the same edge as the 16th falling `sck`.
- R6: `sdo` is sampled on the clock edge at which the controller drives `sck` low. The first sample is the bit present before any `sck` edge. The 16 samples form the word MSB first, and device i's word appears at `res_data[16*i +: 16]`.
- R7: `cnv` stays high from its rise until the last device is deselected. It falls on the same edge where `res_valid` rises.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid` stays high, `res_data` is unchanged and no conversion starts, even with `start` high. `res_valid` falls on the edge after `res_ready` is seen high.
- R9: After `cnv` falls, `cnv` stays low for at least `ACQ_CYC`+1 cycles, and exactly that long when `start` and `res_ready` are held high. A `start` pulse during a conversion or acquisition is ignored.
- R10: `sck` is 0 whenever no select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a conversion-and-readout cycle |
| res_ready | input | 1 | Host accepts the result word set |
| sdo | input | 1 | Shared serial data line from the converters |
| cnv | output | 1 | Shared conversion line |
| sck | output | 1 | Shared serial clock |
| sel_n | output | NDEV | Per-device active-low select |
| res_valid | output | 1 | Result word set is available |
| res_data | output | NDEV*W | Captured words, device i at bits [W*i +: W] |

## Verification
The assertions assume that `res_ready` is a plain level and that the timing parameters are all at least 1. The bench keeps within both: it drives every input only on falling clock edges and builds the design with small non-zero counts. The bench stands in for the converters with a model that places the MSB on `sdo` when its select falls, and shifts to the next bit only after a falling `sck`. This respects the hold time that falling-edge sampling relies on. Back-pressure is exercised only with `start` held high, so the check that no conversion starts is a real one.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_EN,
    ST_HIGH,
    ST_LOW,
    ST_DESEL,
    ST_ACQ
  } rd_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val - CW'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {word[W-2:0], din};
    end
  end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int NDEV     = 2,
  parameter int W        = 16,
  parameter int CONV_CYC = 200,
  parameter int EN_CYC   = 2,
  parameter int SCKH_CYC = 2,
  parameter int SCKL_CYC = 2,
  parameter int ACQ_CYC  = 50,
  parameter int CW       = 8,
  parameter int DW       = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            res_ready,
  input  logic            tmr_done,
  output logic            tmr_load,
  output logic [CW-1:0]   tmr_val,
  output logic            shift_en,
  output logic            store,
  output logic [DW-1:0]   dev,
  output logic            cnv,
  output logic            sck,
  output logic [NDEV-1:0] sel_n,
  output logic            res_valid
);
  localparam int BW = $clog2(W);

  rd_state_t     state, nxt;
  logic [DW-1:0] dev_n;
  logic [BW-1:0] bitc;
  logic          sel_phase;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = CW'(1);
    shift_en = 1'b0;
    store    = 1'b0;
    dev_n    = dev;
    unique case (state)
      ST_IDLE: if (start && !res_valid) begin
        nxt = ST_CONV; tmr_load = 1'b1; tmr_val = CW'(CONV_CYC);
      end
      ST_CONV: if (tmr_done) begin
        nxt = ST_EN; tmr_load = 1'b1; tmr_val = CW'(EN_CYC); dev_n = '0;
      end
      ST_EN: if (tmr_done) begin
        nxt = ST_HIGH; tmr_load = 1'b1; tmr_val = CW'(SCKH_CYC);
      end
      ST_HIGH: if (tmr_done) begin
        shift_en = 1'b1;
        tmr_load = 1'b1;
        if (bitc == BW'(W-1)) begin
          nxt = ST_DESEL; tmr_val = CW'(1);
        end else begin
          nxt = ST_LOW; tmr_val = CW'(SCKL_CYC);
        end
      end
      ST_LOW: if (tmr_done) begin
        nxt = ST_HIGH; tmr_load = 1'b1; tmr_val = CW'(SCKH_CYC);
      end
      ST_DESEL: begin
        store    = 1'b1;
        tmr_load = 1'b1;
        if (dev == DW'(NDEV-1)) begin
          nxt = ST_ACQ; tmr_val = CW'(ACQ_CYC);
        end else begin
          nxt = ST_EN; tmr_val = CW'(EN_CYC); dev_n = dev + DW'(1);
        end
      end
      ST_ACQ: if (tmr_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign sel_phase = (nxt == ST_EN) || (nxt == ST_HIGH) || (nxt == ST_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dev       <= '0;
      bitc      <= '0;
      cnv       <= 1'b0;
      sck       <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      state <= nxt;
      dev   <= dev_n;
      cnv   <= (nxt == ST_CONV) || sel_phase || (nxt == ST_DESEL);
      sck   <= (nxt == ST_HIGH);
      if (state == ST_EN && nxt == ST_HIGH) begin
        bitc <= '0;
      end else if (shift_en) begin
        bitc <= bitc + BW'(1);
      end
      if (state == ST_DESEL && nxt == ST_ACQ) begin
        res_valid <= 1'b1;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NDEV; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_n[i] <= 1'b1;
      end else begin
        sel_n[i] <= !(sel_phase && (dev_n == DW'(i)));
      end
    end
  end
endmodule

// File: rtl/adc_multi_reader.sv
module adc_multi_reader
  import adc_rd_pkg::*;
#(
  parameter int NDEV     = 2,
  parameter int W        = 16,
  parameter int CONV_CYC = 200,
  parameter int EN_CYC   = 2,
  parameter int SCKH_CYC = 2,
  parameter int SCKL_CYC = 2,
  parameter int ACQ_CYC  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              res_ready,
  input  logic              sdo,
  output logic              cnv,
  output logic              sck,
  output logic [NDEV-1:0]   sel_n,
  output logic              res_valid,
  output logic [NDEV*W-1:0] res_data
);
  localparam int MAXC = max2(max2(max2(CONV_CYC, ACQ_CYC), max2(SCKH_CYC, SCKL_CYC)), EN_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam int DW   = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic          tmr_load, tmr_done, shift_en, store;
  logic [CW-1:0] tmr_val;
  logic [DW-1:0] dev;
  logic [W-1:0]  word;

  adc_rd_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .done(tmr_done)
  );

  adc_rd_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(sdo), .word(word)
  );

  adc_rd_seq #(
    .NDEV(NDEV), .W(W), .CONV_CYC(CONV_CYC), .EN_CYC(EN_CYC),
    .SCKH_CYC(SCKH_CYC), .SCKL_CYC(SCKL_CYC), .ACQ_CYC(ACQ_CYC),
    .CW(CW), .DW(DW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .res_ready(res_ready),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .shift_en(shift_en), .store(store), .dev(dev),
    .cnv(cnv), .sck(sck), .sel_n(sel_n), .res_valid(res_valid)
  );

  for (genvar i = 0; i < NDEV; i++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_data[W*i +: W] <= '0;
      end else if (store && dev == DW'(i)) begin
        res_data[W*i +: W] <= word;
      end
    end
  end
endmodule

// File: rtl/adc_multi_reader_chk.sv
module adc_multi_reader_chk #(
  parameter int NDEV = 2,
  parameter int W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              res_ready,
  input logic              cnv,
  input logic              sck,
  input logic [NDEV-1:0]   sel_n,
  input logic              res_valid,
  input logic [NDEV*W-1:0] res_data
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n) <= 1); // R3

  AST_CNV_RISE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv) |-> (&sel_n)); // R2

  AST_SEL_INSIDE_CNV: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sel_n) |-> cnv); // R7

  AST_CNV_FALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv) |-> $rose(res_valid)); // R7

  AST_SCK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !(&sel_n)); // R10

  AST_HOLD_UNDER_BP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R8

  AST_NO_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> !$rose(cnv)); // R8
endmodule

bind adc_multi_reader adc_multi_reader_chk #(.NDEV(NDEV), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .res_ready(res_ready),
  .cnv(cnv), .sck(sck), .sel_n(sel_n), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/adc_multi_reader_test.sv
module adc_multi_reader_test;
  localparam int NDEV = 3;
  localparam int W    = 16;
  localparam int CONV = 20;
  localparam int ENC  = 2;
  localparam int SH   = 2;
  localparam int SL   = 3;
  localparam int ACQ  = 10;
  localparam int NV   = 5;

  localparam logic [NDEV*W-1:0] VEC [NV] = '{
    48'h1234_ABCD_8001,
    48'h0000_FFFF_0000,
    48'hA5A5_5A5A_A5A5,
    48'h0001_8000_7FFE,
    48'hFFFF_0000_C3C3
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, res_ready = 1'b1;
  logic sdo, cnv, sck, res_valid;
  logic [NDEV-1:0]   sel_n;
  logic [NDEV*W-1:0] res_data;

  int tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  adc_multi_reader #(
    .NDEV(NDEV), .W(W), .CONV_CYC(CONV), .EN_CYC(ENC),
    .SCKH_CYC(SH), .SCKL_CYC(SL), .ACQ_CYC(ACQ)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .res_ready(res_ready), .sdo(sdo),
    .cnv(cnv), .sck(sck), .sel_n(sel_n), .res_valid(res_valid), .res_data(res_data)
  );

  // converter model
  logic [W-1:0] word [NDEV];
  logic [W-1:0] sh   [NDEV];
  int           bcnt [NDEV];

  always_comb begin
    sdo = 1'b0;
    for (int i = 0; i < NDEV; i++)
      if (!sel_n[i] && bcnt[i] < W) sdo = sdo | sh[i][W-1];
  end

  // monitors
  logic p_cnv = 1'b0, p_sck = 1'b0;
  logic [NDEV-1:0] p_sel = '1;
  int conv_cnt, en_run, cur, ord_idx, low_run, high_run, clow, last_low, rises;
  int werr, nosel_err;
  bit first_sel, risen;
  int ord [NDEV];
  int en_meas [NDEV];
  int falls [NDEV];

  initial begin
    conv_cnt = 0; en_run = 0; cur = 0; ord_idx = 0; low_run = 0; high_run = 0;
    clow = 0; last_low = 0; rises = 0; werr = 0; nosel_err = 0;
    first_sel = 0; risen = 0;
    for (int i = 0; i < NDEV; i++) begin
      word[i] = '0; sh[i] = '0; bcnt[i] = W; ord[i] = -1; en_meas[i] = 0; falls[i] = 0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < NDEV; i++) begin
      if (p_sel[i] && !sel_n[i]) begin
        sh[i] = word[i]; bcnt[i] = 0;
        if (ord_idx < NDEV) ord[ord_idx] = i;
        ord_idx++; cur = i; falls[i] = 0; en_run = 1; risen = 0; first_sel = 1;
      end else if (!sel_n[i] && p_sck && !sck) begin
        sh[i] = sh[i] << 1; bcnt[i]++;
      end
    end
    if (!cnv) clow++;
    else if (!p_cnv) begin
      last_low = clow; clow = 0; rises++; conv_cnt = 1; first_sel = 0; ord_idx = 0;
    end else if ((&sel_n) && !first_sel) conv_cnt++;
    if (sck) begin
      if (!p_sck) begin
        if (!risen) begin en_meas[cur] = en_run; risen = 1; end
        else if (low_run != SL) werr++;
        high_run = 1;
      end else high_run++;
    end else begin
      if (p_sck) begin
        if (high_run != SH) werr++;
        falls[cur]++; low_run = 1;
      end else begin
        low_run++;
        if (!(&sel_n) && !risen && !(p_sel[cur] && !sel_n[cur])) en_run++;
      end
    end
    if (sck && (&sel_n)) nosel_err++;
    p_cnv = cnv; p_sck = sck; p_sel = sel_n;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; step(1); start = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    int t = 0;
    while (!res_valid && t < 5000) begin step(1); t++; end
    if (!res_valid) begin
      tests++; fails++;
      $display("FAIL %s actual=timeout expected=res_valid", req);
    end
  endtask

  initial begin
    logic [NDEV*W-1:0] held;
    int r0;
    step(3);
    // R1 reset state
    check("R1", {cnv, sck, sel_n, res_valid}, {1'b0, 1'b0, {NDEV{1'b1}}, 1'b0});
    rst_n = 1'b1;
    step(1);
    check("R1", {cnv, sck, sel_n, res_valid}, {1'b0, 1'b0, {NDEV{1'b1}}, 1'b0});

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < NDEV; i++) word[i] = VEC[v][W*i +: W];
      pulse_start();
      wait_valid("R7");
      check("R7", {cnv, res_valid}, 2'b01);
      for (int i = 0; i < NDEV; i++) begin
        check("R6", res_data[W*i +: W], VEC[v][W*i +: W]);
        check("R3", ord[i], i);
        check("R4", en_meas[i], ENC);
        check("R5", falls[i], W);
      end
      check("R2", conv_cnt, CONV);
      step(ACQ + 3);
    end
    check("R5", werr, 0);
    check("R10", nosel_err, 0);

    // R9: start during conversion is ignored
    r0 = rises;
    pulse_start(); step(5); pulse_start();
    wait_valid("R9");
    step(ACQ + 5);
    check("R9", rises - r0, 1);

    // R8: back-pressure holds result and blocks a new conversion
    for (int i = 0; i < NDEV; i++) word[i] = 16'h1111 * (i + 3);
    res_ready = 1'b0;
    pulse_start();
    wait_valid("R8");
    held = res_data; r0 = rises;
    start = 1'b1;
    step(ACQ + 40);
    check("R8", {res_valid, cnv}, 2'b10);
    check("R8", res_data, held);
    check("R8", rises - r0, 0);
    start = 1'b0;
    for (int i = 0; i < NDEV; i++) check("R6", res_data[W*i +: W], 16'h1111 * (i + 3));
    res_ready = 1'b1;
    step(1);
    check("R8", res_valid, 1'b0);
    step(ACQ + 3);

    // R9: acquisition gap with start and ready held high
    start = 1'b1;
    wait_valid("R9");
    step(1);
    wait_valid("R9");
    step(1);
    start = 1'b0;
    check("R9", last_low, ACQ + 1);
    step(ACQ + 5);
    check("R10", nosel_err, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule